// File: doc/BRIEF.md
# Register-Mapped SPI Master with FIFOs

This block is an SPI master peripheral that software drives through a small 32-bit register bus. Words to send go into a 16-entry transmit FIFO through a data port. Words shifted in from the slave land in a 16-entry receive FIFO, which is read back through the same port. A control/status word sets the clock mode, the chip-select line and its polarity, the word width and the interrupt enables, and reports the FIFO and completion flags. A divider register sets the serial clock rate.

Shifting runs only while the run bit is set. A slave therefore stays selected across several refills of the transmit FIFO. The interrupt output is a level signal. It is raised by completion, when the transmit FIFO has drained, or by the receive FIFO reaching three quarters full. A 9-bit word mode sends a command/data flag ahead of each byte.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the control word reads 0x0004_0000: only the TX-room flag (bit 18) is set. sclk_o is 0, every cs_o line is 1, irq_o is 0 and the divider reads 0.
- R2: The register offsets are 0x0 for control/status, 0x4 for the FIFO data port and 0x8 for the divider. The divider's 16 bits read back as written.
- R3: Bit 3 is CPOL and bit 2 is CPHA. Words shift MSB first. With CPHA=0, MISO is sampled on the leading edge; with CPHA=1 it is sampled on the trailing edge. Each transmitted word pushes one received word into the RX FIFO. sclk_o rests at CPOL whenever no word is shifting.
- R4: Each sclk half period lasts max(div/2, 1) core cycles. A divider of 0 counts as 65536, which gives 32768 cycles per half period.
- R5: Bit 7 is the run bit. While it is 0, no word leaves the TX FIFO and no chip select is active. A word already shifting completes and keeps its select asserted until it finishes.
- R6: Bits 1:0 pick line 0, 1 or 2, and 3 picks none. The active level of line i is 1 when bit 21+i or bit 6 is set, and 0 otherwise. Only the picked line is active, and only while running or shifting.
- R7: Bit 16 (done) is 1 exactly when run is set, the TX FIFO is empty and no word is shifting.
- R8: Status bit 17 means the RX FIFO holds data. Bit 19 means it holds at least 12 entries. Bit 20 means it holds 16. Words received while it is full are dropped.
- R9: irq_o = (bit 9 AND done) OR (bit 10 AND bit 19).
- R10: Writing 1 to bit 4 empties the TX FIFO and writing 1 to bit 5 empties the RX FIFO. Both bits read back as 0.
- R11: A data-port read returns the oldest RX word and pops it. With the RX FIFO empty it returns 0 and pops nothing. A data-port write while the TX FIFO holds 16 entries is dropped.
- R12: Bit 13 selects 9-bit words. Data-port bits 8:0 are sent MSB first, and 9 received bits are returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4 | Register byte offset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (pops RX on the data port) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 3 | Chip-select lines, per-line polarity |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest states to reach are the full-FIFO corners: a 17th transmit write that must be dropped, a receive FIFO that crosses the 12-entry threshold, and a read of an empty receive FIFO. The bench stages 17 writes with the run bit clear and then lets the engine drain them. The count of words that come back proves the drop, and the flags and the interrupt are checked at the threshold and at full. The 65536 divide is measured as the spacing of two sclk edges, and reset then ends the slow word.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int NCS = 3;
  localparam logic [3:0] ADDR_CTRL = 4'h0;
  localparam logic [3:0] ADDR_DATA = 4'h4;
  localparam logic [3:0] ADDR_DIV  = 4'h8;

  localparam int B_CPHA     = 2;
  localparam int B_CPOL     = 3;
  localparam int B_CLR_TX   = 4;
  localparam int B_CLR_RX   = 5;
  localparam int B_POL_ALL  = 6;
  localparam int B_RUN      = 7;
  localparam int B_IE_DONE  = 9;
  localparam int B_IE_RX    = 10;
  localparam int B_WIDE     = 13;
  localparam int B_DONE     = 16;
  localparam int B_RX_AVAIL = 17;
  localparam int B_TX_ROOM  = 18;
  localparam int B_RX_HIGH  = 19;
  localparam int B_RX_FULL  = 20;
  localparam int B_POL_LINE = 21;

  typedef struct packed {
    logic [NCS-1:0] pol_line;
    logic           wide;
    logic           ie_rx;
    logic           ie_done;
    logic           run;
    logic           pol_all;
    logic           cpol;
    logic           cpha;
    logic [1:0]     sel;
  } ctrl_t;
endpackage

// File: rtl/spi_fifo_buf.sv
module spi_fifo_buf #(
  parameter int W     = 9,
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o,
  output logic [LW:0]  level_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [LW-1:0] wp_q, rp_q;
  logic [LW:0]   cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (LW+1)'(DEPTH));
  assign level_o = cnt_q;
  assign dout_o  = mem[rp_q];
  assign do_push = push_i && !full_o && !clr_i;
  assign do_pop  = pop_i && !empty_o && !clr_i;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == LW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == LW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int HW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [8:0]    word_i,
  input  logic          wide_i,
  input  logic          cpol_i,
  input  logic          cpha_i,
  input  logic [HW-1:0] half_i,
  input  logic          miso_i,
  output logic          busy_o,
  output logic          sclk_o,
  output logic          mosi_o,
  output logic          rx_valid_o,
  output logic [8:0]    rx_word_o
);
  logic [HW-1:0] tmr_q;
  logic [4:0]    edge_q;
  logic          sck_q;
  logic [8:0]    tx_sr, rx_sr;
  logic [4:0]    last_edge;
  logic [8:0]    rx_fin;

  assign last_edge = wide_i ? 5'd17 : 5'd15;
  assign sclk_o    = sck_q ^ cpol_i;
  assign mosi_o    = wide_i ? tx_sr[8] : tx_sr[7];
  // on the last trailing edge with CPHA=1 the final bit arrives this cycle
  assign rx_fin    = cpha_i ? {rx_sr[7:0], miso_i} : rx_sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o     <= 1'b0;
      tmr_q      <= '0;
      edge_q     <= '0;
      sck_q      <= 1'b0;
      tx_sr      <= '0;
      rx_sr      <= '0;
      rx_valid_o <= 1'b0;
      rx_word_o  <= '0;
    end else begin
      rx_valid_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o <= 1'b1;
          tx_sr  <= word_i;
          rx_sr  <= '0;
          tmr_q  <= half_i - 1'b1;
          edge_q <= '0;
          sck_q  <= 1'b0;
        end
      end else if (tmr_q != '0) begin
        tmr_q <= tmr_q - 1'b1;
      end else begin
        tmr_q  <= half_i - 1'b1;
        sck_q  <= ~sck_q;
        edge_q <= edge_q + 1'b1;
        if (!sck_q) begin
          if (!cpha_i)             rx_sr <= {rx_sr[7:0], miso_i};
          else if (edge_q != '0)   tx_sr <= tx_sr << 1;
        end else begin
          if (cpha_i) rx_sr <= {rx_sr[7:0], miso_i};
          else        tx_sr <= tx_sr << 1;
          if (edge_q == last_edge) begin
            busy_o     <= 1'b0;
            rx_valid_o <= 1'b1;
            rx_word_o  <= wide_i ? rx_fin : {1'b0, rx_fin[7:0]};
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV_W = 16,
  localparam int LW      = $clog2(DEPTH),
  localparam int RX_HIGH = DEPTH * 3 / 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [3:0]     addr_i,
  input  logic           wr_en_i,
  input  logic           rd_en_i,
  input  logic [31:0]    wdata_i,
  output logic [31:0]    rdata_o,
  output logic           sclk_o,
  output logic           mosi_o,
  input  logic           miso_i,
  output logic [NCS-1:0] cs_o,
  output logic           irq_o
);
  ctrl_t            ctrl_q;
  logic [DIV_W-1:0] div_q, half;
  logic             wr_ctrl, clr_tx, clr_rx, tx_push, rx_pop, start;
  logic [8:0]       tx_dout, rx_dout, rx_word;
  logic             tx_empty, tx_full, rx_empty, rx_full, rx_valid;
  logic [LW:0]      tx_level, rx_level;
  logic             eng_busy, done, rx_high, cs_on;
  logic [NCS-1:0]   pol_vec;
  logic             unused_bits;

  assign wr_ctrl = wr_en_i && (addr_i == ADDR_CTRL);
  assign clr_tx  = wr_ctrl && wdata_i[B_CLR_TX];
  assign clr_rx  = wr_ctrl && wdata_i[B_CLR_RX];
  assign tx_push = wr_en_i && (addr_i == ADDR_DATA);
  assign rx_pop  = rd_en_i && (addr_i == ADDR_DATA);
  assign unused_bits = ^{wdata_i[31:24], wdata_i[20:14], wdata_i[12:11], wdata_i[8],
                         wdata_i[5:4], tx_level};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      div_q  <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.sel      <= wdata_i[1:0];
      ctrl_q.cpha     <= wdata_i[B_CPHA];
      ctrl_q.cpol     <= wdata_i[B_CPOL];
      ctrl_q.pol_all  <= wdata_i[B_POL_ALL];
      ctrl_q.run      <= wdata_i[B_RUN];
      ctrl_q.ie_done  <= wdata_i[B_IE_DONE];
      ctrl_q.ie_rx    <= wdata_i[B_IE_RX];
      ctrl_q.wide     <= wdata_i[B_WIDE];
      ctrl_q.pol_line <= wdata_i[B_POL_LINE +: NCS];
    end else if (wr_en_i && addr_i == ADDR_DIV) begin
      div_q <= wdata_i[DIV_W-1:0];
    end
  end

  // divider 0 means the full 2^DIV_W range
  always_comb begin
    if (div_q == '0)                    half = DIV_W'(1) << (DIV_W - 1);
    else if (div_q[DIV_W-1:1] == '0)    half = DIV_W'(1);
    else                                half = {1'b0, div_q[DIV_W-1:1]};
  end

  assign start   = ctrl_q.run && !tx_empty && !eng_busy;
  assign done    = ctrl_q.run && tx_empty && !eng_busy;
  assign rx_high = (rx_level >= (LW+1)'(RX_HIGH));
  assign irq_o   = (ctrl_q.ie_done && done) || (ctrl_q.ie_rx && rx_high);
  assign cs_on   = ctrl_q.run || eng_busy;
  assign pol_vec = ctrl_q.pol_line | {NCS{ctrl_q.pol_all}};

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_o[i] = (cs_on && ctrl_q.sel == 2'(i)) ? pol_vec[i] : ~pol_vec[i];
  end

  spi_fifo_buf #(.W(9), .DEPTH(DEPTH)) tx_fifo_i (
    .clk_i, .rst_ni, .clr_i(clr_tx), .push_i(tx_push), .din_i(wdata_i[8:0]),
    .pop_i(start), .dout_o(tx_dout), .empty_o(tx_empty), .full_o(tx_full),
    .level_o(tx_level)
  );

  spi_fifo_buf #(.W(9), .DEPTH(DEPTH)) rx_fifo_i (
    .clk_i, .rst_ni, .clr_i(clr_rx), .push_i(rx_valid), .din_i(rx_word),
    .pop_i(rx_pop), .dout_o(rx_dout), .empty_o(rx_empty), .full_o(rx_full),
    .level_o(rx_level)
  );

  spi_shift_engine #(.HW(DIV_W)) eng_i (
    .clk_i, .rst_ni, .start_i(start), .word_i(tx_dout), .wide_i(ctrl_q.wide),
    .cpol_i(ctrl_q.cpol), .cpha_i(ctrl_q.cpha), .half_i(half), .miso_i,
    .busy_o(eng_busy), .sclk_o, .mosi_o, .rx_valid_o(rx_valid), .rx_word_o(rx_word)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: begin
        rdata_o[1:0]                = ctrl_q.sel;
        rdata_o[B_CPHA]             = ctrl_q.cpha;
        rdata_o[B_CPOL]             = ctrl_q.cpol;
        rdata_o[B_POL_ALL]          = ctrl_q.pol_all;
        rdata_o[B_RUN]              = ctrl_q.run;
        rdata_o[B_IE_DONE]          = ctrl_q.ie_done;
        rdata_o[B_IE_RX]            = ctrl_q.ie_rx;
        rdata_o[B_WIDE]             = ctrl_q.wide;
        rdata_o[B_DONE]             = done;
        rdata_o[B_RX_AVAIL]         = !rx_empty;
        rdata_o[B_TX_ROOM]          = !tx_full;
        rdata_o[B_RX_HIGH]          = rx_high;
        rdata_o[B_RX_FULL]          = rx_full;
        rdata_o[B_POL_LINE +: NCS]  = ctrl_q.pol_line;
      end
      ADDR_DATA: if (!rx_empty) rdata_o[8:0] = rx_dout;
      ADDR_DIV:  rdata_o[DIV_W-1:0] = div_q;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH)
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sclk_o,
  input logic [2:0]  cs_o,
  input logic        irq_o,
  input logic        cpol,
  input logic        busy,
  input logic        ta,
  input logic [1:0]  sel,
  input logic [2:0]  pol_line,
  input logic        pol_all,
  input logic        ie_done,
  input logic        ie_rx,
  input logic [LW:0] rx_level
);
  logic [2:0] cs_act;
  assign cs_act = ~(cs_o ^ (pol_line | {3{pol_all}}));

  AST_SCLK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> sclk_o == cpol); // R3
  AST_NO_TA_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ta && !busy) |=> !busy); // R5
  AST_CS_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_act)); // R6
  AST_CS_DURING_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && sel != 2'd3) |-> $countones(cs_act) == 1); // R5
  AST_RX_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_level <= (LW+1)'(DEPTH)); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ie_done && !ie_rx) |-> !irq_o); // R9
endmodule

bind spi_fifo_master spi_fifo_master_chk #(.DEPTH(DEPTH)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .sclk_o(sclk_o), .cs_o(cs_o), .irq_o(irq_o),
  .cpol(ctrl_q.cpol), .busy(eng_busy), .ta(ctrl_q.run), .sel(ctrl_q.sel),
  .pol_line(ctrl_q.pol_line), .pol_all(ctrl_q.pol_all), .ie_done(ctrl_q.ie_done),
  .ie_rx(ctrl_q.ie_rx), .rx_level(rx_level)
);

// File: tb/spi_fifo_master_tb.sv
module spi_fifo_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // {cpol, cpha, wide, tx[8:0], slave pattern[8:0]}
  localparam logic [20:0] VEC [NV] = '{
    {3'b000, 9'h0A5, 9'h03C},
    {3'b010, 9'h0C3, 9'h081},
    {3'b100, 9'h01F, 9'h0E7},
    {3'b110, 9'h080, 9'h001},
    {3'b001, 9'h1A5, 9'h15A},
    {3'b111, 9'h103, 9'h0FE}
  };

  logic        clk = 0, rst_n = 0;
  logic [3:0]  addr = '0;
  logic        wr_en = 0, rd_en = 0;
  logic [31:0] wdata = '0, rdata;
  logic        sclk, mosi, irq;
  logic        miso = 0;
  logic [2:0]  cs;
  int          n_tests = 0, n_fail = 0;

  logic        slave_en = 0, cpol_tb = 0, cpha_tb = 0;
  logic [31:0] stx = '0, srx = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_fifo_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso),
    .cs_o(cs), .irq_o(irq)
  );

  // slave model
  always @(sclk) begin
    if (slave_en) begin
      if (sclk != cpol_tb) begin
        if (cpha_tb) begin miso = stx[31]; stx = stx << 1; end
        else srx = {srx[30:0], mosi};
      end else begin
        if (cpha_tb) srx = {srx[30:0], mosi};
        else begin stx = stx << 1; miso = stx[31]; end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(4'h0, s);
      if (s[16]) break;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++; n_tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r, base;
    longint t1, t2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(4'h0, r); chk("R1 ctrl", r, 32'h0004_0000);
    chk("R1 pins", {28'd0, sclk, cs}, {28'd0, 1'b0, 3'b111});
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(4'h8, r); chk("R1 div", r, 32'd0);
    // R2 divider readback
    wr(4'h8, 32'h0000_0004);
    rd(4'h8, r); chk("R2 div", r, 32'h4);

    // R3/R12 vector table
    for (int v = 0; v < NV; v++) begin
      logic wide;
      logic [8:0] txw, pat, got;
      {cpol_tb, cpha_tb, wide, txw, pat} = VEC[v];
      base = {18'd0, wide, 9'd0, cpol_tb, cpha_tb, 2'b00};
      wr(4'h0, base | 32'h30);
      stx = wide ? {pat, 23'd0} : {pat[7:0], 24'd0};
      srx = '0; miso = stx[31]; slave_en = 1;
      wr(4'h4, {23'd0, txw});
      wr(4'h0, base | 32'h80);
      wait_done();
      got = wide ? srx[8:0] : {1'b0, srx[7:0]};
      chk(wide ? "R12 mosi" : "R3 mosi", {23'd0, got}, {23'd0, wide ? txw : {1'b0, txw[7:0]}});
      slave_en = 0;
      wr(4'h0, base);
      chk("R3 idle sclk", {31'd0, sclk}, {31'd0, cpol_tb});
      rd(4'h4, r);
      chk(wide ? "R12 miso" : "R3 miso", r, {23'd0, wide ? pat : {1'b0, pat[7:0]}});
    end

    // R5 run gating
    wr(4'h0, 32'h30);
    wr(4'h4, 32'h55);
    repeat (40) @(negedge clk);
    chk("R5 sclk", {31'd0, sclk}, 32'd0);
    chk("R5 cs", {29'd0, cs}, 32'd7);
    rd(4'h0, r); chk("R5 rx/done", {30'd0, r[17:16]}, 32'd0);
    // R10 clear TX, clear bits read 0
    wr(4'h0, 32'h10);
    rd(4'h0, r); chk("R10 clr readback", {30'd0, r[5:4]}, 32'd0);
    wr(4'h0, 32'h80);
    rd(4'h0, r); chk("R7 done empty", {31'd0, r[16]}, 32'd1);
    chk("R10 tx flushed", {31'd0, sclk}, 32'd0);
    // R9 done irq
    wr(4'h0, 32'h280);
    #1 chk("R9 irq done", {31'd0, irq}, 32'd1);
    wr(4'h0, 32'h200);
    #1 chk("R9 irq no run", {31'd0, irq}, 32'd0);
    rd(4'h0, r); chk("R7 done run0", {31'd0, r[16]}, 32'd0);

    // R6 chip select lines
    wr(4'h0, 32'h0000_0081);
    chk("R6 line1 low", {29'd0, cs}, 32'd5);
    wr(4'h0, 32'h0040_0001);
    chk("R6 pol1 idle", {29'd0, cs}, 32'd5);
    wr(4'h0, 32'h0040_0081);
    chk("R6 pol1 run", {29'd0, cs}, 32'd7);
    wr(4'h0, 32'h0000_0042);
    chk("R6 all pol idle", {29'd0, cs}, 32'd0);
    wr(4'h0, 32'h0000_00C2);
    chk("R6 all pol line2", {29'd0, cs}, 32'd4);
    wr(4'h0, 32'h0000_0083);
    chk("R6 none", {29'd0, cs}, 32'd7);

    // R8/R11 full FIFOs
    wr(4'h0, 32'h30);
    for (int i = 0; i < 17; i++) wr(4'h4, 32'h0);
    rd(4'h0, r); chk("R11 tx full", {31'd0, r[18]}, 32'd0);
    miso = 1;
    wr(4'h0, 32'h80);
    wait_done();
    rd(4'h0, r); chk("R8 flags", {29'd0, r[20:19], r[17]}, 32'd7);
    wr(4'h0, 32'h400);
    #1 chk("R9 irq rx", {31'd0, irq}, 32'd1);
    for (int i = 0; i < 16; i++) begin
      rd(4'h4, r);
      if (i == 0 || i == 15) chk("R11 rx data", r, 32'hFF);
      if (i == 4) begin
        rd(4'h0, r); chk("R8 below high", {30'd0, r[19], r[17]}, 32'd1);
        #1 chk("R9 irq low", {31'd0, irq}, 32'd0);
      end
    end
    rd(4'h4, r); chk("R11 empty read", r, 32'd0);
    rd(4'h0, r); chk("R8 empty", {31'd0, r[17]}, 32'd0);
    // R10 clear RX
    miso = 0;
    wr(4'h4, 32'h0); wr(4'h0, 32'h80); wait_done();
    wr(4'h0, 32'h20);
    rd(4'h0, r); chk("R10 rx cleared", {31'd0, r[17]}, 32'd0);

    // R4 divider timing
    wr(4'h8, 32'd6);
    wr(4'h4, 32'h0); wr(4'h0, 32'h80);
    @(sclk); t1 = $time; @(sclk); t2 = $time;
    chk("R4 half div6", 32'((t2 - t1) / CLK_PERIOD), 32'd3);
    wait_done();
    wr(4'h8, 32'd0);
    wr(4'h4, 32'h0); wr(4'h0, 32'h80);
    @(sclk); t1 = $time; @(sclk); t2 = $time;
    chk("R4 half div0", 32'((t2 - t1) / CLK_PERIOD), 32'd32768);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 re-reset", {28'd0, sclk, cs}, {28'd0, 1'b0, 3'b111});

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule